// File: doc/BRIEF.md
# Segmented Address Translator with Length Guard

This block converts a segmented virtual address, made of a segment selector and a byte offset, into a physical address. It keeps a small table of segment descriptors. Each descriptor holds a base address, a length, a present flag, a modified flag and a short attribute field. A request is captured in a register. In the following cycle the block looks up the selected descriptor, checks it, and presents a one-cycle response.

The physical address is the full-width sum of the descriptor base and the offset, so a segment may start at any address. The response carries a fault code. The block reports a missing segment, an offset at or beyond the segment length, and a sum that does not fit in the physical address width. A write that completes with no fault marks its segment as modified. A configuration port loads whole descriptors, and the same table serves the translation path.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is low and every descriptor is cleared. A request to any segment that has not been configured since reset returns fault code 1 (absent) with attribute 0 and rsp_dirty 0.
- R2: A request sampled with req_valid high at a rising edge produces rsp_valid high for exactly the following cycle. A cycle whose request was sampled low has rsp_valid low.
- R3: When the fault code is 0, rsp_pa equals the descriptor base plus the zero-extended 28-bit offset. The 4-bit req_seg selects one of 16 descriptors.
- R4: A descriptor whose present flag is clear gives fault code 1. This check has the highest priority and overrides the length and overflow checks.
- R5: For a present descriptor, an offset greater than or equal to the length gives fault code 2. The offset length-1 is legal, and a length of 0 faults every offset. This check has priority over overflow.
- R6: For a present descriptor with the offset inside the length, a base-plus-offset sum that carries out of bit 31 gives fault code 3.
- R7: When the fault code is non-zero, rsp_pa is 0.
- R8: A write request with fault code 0 sets the modified flag of its descriptor at the rising edge that ends its response cycle. rsp_dirty shows the flag as it stands after the access, including that write. Reads and faulting writes leave the flag unchanged.
- R9: A configuration write at a rising edge loads base, length, present, modified and attribute into the descriptor at cfg_idx. A response in the cycle after that edge uses the new descriptor. If the configuration write and a modified-flag update land on the same descriptor at the same edge, the configuration write wins.
- R10: rsp_attr reports the attribute field of the selected descriptor, whatever the fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a descriptor this cycle |
| cfg_idx | input | 4 | Descriptor index to load |
| cfg_base | input | 32 | Segment base address |
| cfg_len | input | 28 | Segment length in bytes |
| cfg_present | input | 1 | Present flag to load |
| cfg_mod | input | 1 | Modified flag to load |
| cfg_attr | input | 2 | Attribute field to load |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a write |
| req_seg | input | 4 | Segment selector |
| req_off | input | 28 | Offset within the segment |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 absent, 2 bound, 3 overflow |
| rsp_attr | output | 2 | Attribute of the selected descriptor |
| rsp_dirty | output | 1 | Modified flag after this access |

## Verification
Some properties are checked in every cycle: the strobe timing, the zeroed address on faults, the dominance of the absent check, the bound fault for out-of-range offsets, and the dirty indication on clean writes. Other behaviour can only be shown by the bench's scenarios. That covers the exact sum values near the 32-bit wrap, the order between the bound and overflow checks, whether the modified flag persists or stays clear across later accesses, and a configuration write that collides with a modified-flag update. Reset clearing of descriptors is also shown through the scenarios.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    parameter int SEG_W  = 4;
    parameter int OFF_W  = 28;
    parameter int PA_W   = 32;
    parameter int ATTR_W = 2;

    localparam int NSEG = 1 << SEG_W;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_BOUND  = 2'd2,
        FLT_OVF    = 2'd3
    } flt_e;

    typedef struct packed {
        logic              present;
        logic              modified;
        logic [ATTR_W-1:0] attr;
        logic [OFF_W-1:0]  len;
        logic [PA_W-1:0]   base;
    } desc_t;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } req_t;

    // Fault priority: absent, then bound, then carry out of the sum.
    function automatic flt_e classify(input desc_t d,
                                      input logic [OFF_W-1:0] off,
                                      input logic carry);
        flt_e f;
        if (!d.present)       f = FLT_ABSENT;
        else if (off >= d.len) f = FLT_BOUND;
        else if (carry)        f = FLT_OVF;
        else                   f = FLT_NONE;
        return f;
    endfunction

endpackage

// File: rtl/seg_req_stage.sv
module seg_req_stage
    import seg_xlate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req_d,
    output req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= req_d.valid;
            if (req_d.valid) begin
                req_q.write <= req_d.write;
                req_q.seg   <= req_d.seg;
                req_q.off   <= req_d.off;
            end
        end
    end
endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  desc_t            cfg_desc,
    input  logic             mark_en,
    input  logic [SEG_W-1:0] mark_idx,
    input  logic [SEG_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    desc_t ent_w [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        desc_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (cfg_we && cfg_idx == SEG_W'(i)) begin
                r <= cfg_desc;
            end else if (mark_en && mark_idx == SEG_W'(i)) begin
                r.modified <= 1'b1;
            end
        end
        assign ent_w[i] = r;
    end

    assign rd_desc = ent_w[rd_idx];
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_xlate_pkg::*;
(
    input  req_t            req,
    input  desc_t           desc,
    output logic [PA_W-1:0] pa,
    output flt_e            fault,
    output logic            mark,
    output logic            dirty
);
    logic [PA_W:0] sum;

    always_comb begin
        sum   = {1'b0, desc.base} + {{(PA_W + 1 - OFF_W){1'b0}}, req.off};
        fault = classify(desc, req.off, sum[PA_W]);
        pa    = (fault == FLT_NONE) ? sum[PA_W-1:0] : '0;
        mark  = req.valid && req.write && (fault == FLT_NONE);
        dirty = desc.modified || (req.write && (fault == FLT_NONE));
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [OFF_W-1:0]  cfg_len,
    input  logic              cfg_present,
    input  logic              cfg_mod,
    input  logic [ATTR_W-1:0] cfg_attr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_fault,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_dirty
);
    req_t  req_d, req_q;
    desc_t cfg_desc, sel_desc;
    flt_e  fault;
    logic  mark;
    logic  q_write;
    logic [OFF_W-1:0] q_off;

    always_comb begin
        req_d.valid = req_valid;
        req_d.write = req_write;
        req_d.seg   = req_seg;
        req_d.off   = req_off;
        cfg_desc.present  = cfg_present;
        cfg_desc.modified = cfg_mod;
        cfg_desc.attr     = cfg_attr;
        cfg_desc.len      = cfg_len;
        cfg_desc.base     = cfg_base;
    end

    seg_req_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .req_d (req_d),
        .req_q (req_q)
    );

    seg_desc_table u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_desc (cfg_desc),
        .mark_en  (mark),
        .mark_idx (req_q.seg),
        .rd_idx   (req_q.seg),
        .rd_desc  (sel_desc)
    );

    seg_addr_unit u_addr (
        .req   (req_q),
        .desc  (sel_desc),
        .pa    (rsp_pa),
        .fault (fault),
        .mark  (mark),
        .dirty (rsp_dirty)
    );

    assign q_write   = req_q.write;
    assign q_off     = req_q.off;
    assign rsp_valid = req_q.valid;
    assign rsp_fault = fault;
    assign rsp_attr  = sel_desc.attr;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [1:0]       rsp_fault,
    input logic             rsp_dirty,
    input logic             q_write,
    input logic [OFF_W-1:0] q_off,
    input desc_t            sel_desc
);
    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R2
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7
    a_r7_pa_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_pa == '0);

    // R4
    a_r4_absent_first: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !sel_desc.present) |-> rsp_fault == 2'd1);

    // R5
    a_r5_bound_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && sel_desc.present && q_off >= sel_desc.len) |-> rsp_fault == 2'd2);

    // R8
    a_r8_dirty_on_write: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && q_write && rsp_fault == 2'd0) |-> rsp_dirty);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_fault (rsp_fault),
    .rsp_dirty (rsp_dirty),
    .q_write   (q_write),
    .q_off     (q_off),
    .sel_desc  (sel_desc)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [27:0] cfg_len = '0;
    logic        cfg_present = 1'b0;
    logic        cfg_mod = 1'b0;
    logic [1:0]  cfg_attr = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [27:0] req_off = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_attr;
    logic        rsp_dirty;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_present(cfg_present), .cfg_mod(cfg_mod), .cfg_attr(cfg_attr),
        .req_valid(req_valid), .req_write(req_write), .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_attr(rsp_attr), .rsp_dirty(rsp_dirty)
    );

    typedef struct packed {
        logic [3:0]  seg;
        logic [27:0] off;
        logic        wr;
        logic [1:0]  flt;
        logic [31:0] pa;
        logic        dirty;
        logic [1:0]  attr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 28'h0000020, 1'b0, 2'd0, 32'h0001_0020, 1'b0, 2'd1},  // R3
        '{4'd1, 28'h00000FF, 1'b0, 2'd0, 32'h0001_00FF, 1'b0, 2'd1},  // R5 last legal
        '{4'd1, 28'h0000100, 1'b0, 2'd2, 32'h0000_0000, 1'b0, 2'd1},  // R5 at length
        '{4'd1, 28'h0000100, 1'b1, 2'd2, 32'h0000_0000, 1'b0, 2'd1},  // R8 faulting write
        '{4'd0, 28'h0000010, 1'b0, 2'd1, 32'h0000_0000, 1'b0, 2'd0},  // R4
        '{4'd0, 28'h0000200, 1'b1, 2'd1, 32'h0000_0000, 1'b0, 2'd0},  // R4 over bound
        '{4'd3, 28'h0000000, 1'b0, 2'd2, 32'h0000_0000, 1'b0, 2'd3},  // R5 zero length
        '{4'd2, 28'h0000FFF, 1'b0, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd2},  // R6 top fits
        '{4'd2, 28'h0001000, 1'b0, 2'd3, 32'h0000_0000, 1'b0, 2'd2},  // R6 carry
        '{4'd2, 28'h0002000, 1'b1, 2'd3, 32'h0000_0000, 1'b0, 2'd2},  // R6 R8
        '{4'd1, 28'h0000040, 1'b1, 2'd0, 32'h0001_0040, 1'b1, 2'd1},  // R8 clean write
        '{4'd1, 28'h0000041, 1'b0, 2'd0, 32'h0001_0041, 1'b1, 2'd1},  // R8 persists
        '{4'd5, 28'hFFFFFFE, 1'b0, 2'd0, 32'h3344_FFFE, 1'b0, 2'd0},  // R3 wide
        '{4'd2, 28'h0FFFFFF, 1'b0, 2'd2, 32'h0000_0000, 1'b0, 2'd2},  // R5 over R6
        '{4'd4, 28'h0000000, 1'b0, 2'd1, 32'h0000_0000, 1'b0, 2'd0},  // R1 untouched
        '{4'd2, 28'h0000010, 1'b0, 2'd0, 32'hFFFF_F010, 1'b0, 2'd2}   // R8 stays clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_load(input logic [3:0] idx, input logic [31:0] base,
                            input logic [27:0] len, input logic pres,
                            input logic md, input logic [1:0] at);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_len = len;
        cfg_present = pres; cfg_mod = md; cfg_attr = at;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive at a falling edge; the response is sampled at the next falling edge.
    task automatic issue(input logic [3:0] seg, input logic [27:0] off, input logic wr);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        cfg_load(4'd0, 32'h1000_0000, 28'h0000100, 1'b0, 1'b0, 2'd0);
        cfg_load(4'd1, 32'h0001_0000, 28'h0000100, 1'b1, 1'b0, 2'd1);
        cfg_load(4'd2, 32'hFFFF_F000, 28'h0FFFFFF, 1'b1, 1'b0, 2'd2);
        cfg_load(4'd3, 32'h8000_0000, 28'h0000000, 1'b1, 1'b0, 2'd3);
        cfg_load(4'd5, 32'h2345_0000, 28'hFFFFFFF, 1'b1, 1'b0, 2'd0);

        // Vector table, back to back requests.
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].seg, VECS[i].off, VECS[i].wr);
            check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
            check("R4 R5 R6 fault", {30'd0, rsp_fault}, {30'd0, VECS[i].flt});
            check("R3 R7 pa", rsp_pa, VECS[i].pa);
            check("R8 dirty", {31'd0, rsp_dirty}, {31'd0, VECS[i].dirty});
            check("R10 attr", {30'd0, rsp_attr}, {30'd0, VECS[i].attr});
        end

        // R2: no request, no strobe.
        @(negedge clk);
        check("R2 idle strobe", {31'd0, rsp_valid}, 32'd0);

        // R9: config write at the same edge that captures a request.
        cfg_we = 1'b1; cfg_idx = 4'd1; cfg_base = 32'h0050_0000; cfg_len = 28'h10;
        cfg_present = 1'b1; cfg_mod = 1'b0; cfg_attr = 2'd3;
        issue(4'd1, 28'h8, 1'b0);
        cfg_we = 1'b0;
        check("R9 new base", rsp_pa, 32'h0050_0008);
        check("R9 new attr", {30'd0, rsp_attr}, 32'd3);
        check("R9 new mod", {31'd0, rsp_dirty}, 32'd0);

        // R9: config write collides with a modified-flag update.
        issue(4'd1, 28'h1, 1'b1);
        check("R8 clean write dirty", {31'd0, rsp_dirty}, 32'd1);
        cfg_we = 1'b1; cfg_idx = 4'd1; cfg_base = 32'h0060_0000; cfg_len = 28'h10;
        cfg_present = 1'b1; cfg_mod = 1'b0; cfg_attr = 2'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        issue(4'd1, 28'h2, 1'b0);
        check("R9 config wins", {31'd0, rsp_dirty}, 32'd0);
        check("R9 collided base", rsp_pa, 32'h0060_0002);

        // R1: reset in the middle of a response clears all.
        req_valid = 1'b1; req_seg = 4'd1; req_off = 28'h3; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 strobe cleared", {31'd0, rsp_valid}, 32'd0);
        issue(4'd1, 28'h3, 1'b0);
        check("R1 descriptor cleared", {30'd0, rsp_fault}, 32'd1);
        check("R1 attr cleared", {30'd0, rsp_attr}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule